// File: doc/BRIEF.md
# Warp Issue Sequencer

This block feeds a bank of scalar execution lanes from a pool of resident warps. Each warp is a group of threads that run the same instruction in lockstep. The warp has more threads than there are lanes, so one warp instruction is spread over several consecutive beats. On each beat a different slice of the warp's threads is presented to the lanes. A table inside the block holds the program counter of every resident warp.

The surrounding pipeline supplies two things: a per-warp ready flag, which is dropped while a warp waits on memory, and a per-warp active-thread mask, which holds the threads still on the taken path of a branch. At the end of every instruction the sequencer picks the next warp that can issue, in round-robin order, so a warp that is stalled is passed over. Each cycle it reports the warp ID, that warp's PC, the beat number, the thread index handled by each lane and a lane enable derived from the mask. With the defaults there are 24 warps of 32 threads on 8 lanes, so each instruction takes 4 beats.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset `issue_valid_o` is 0, every lane enable is 0, every warp PC is 0, and the first round-robin search starts at warp 0.
- R2: A warp can be selected only if its `ready_i` bit is 1 and its 32-bit field `act_mask_i[w*32 +: 32]` is not all zero.
- R3: At a selection point the search starts at the warp after the last one granted and wraps around, and the warp that was last granted comes last. The first eligible warp found is granted.
- R4: A selection point is any cycle in which nothing is issuing, or the last beat (beat 3) of an instruction. The granted warp appears at the next clock edge on beat 0. Beats 1, 2 and 3 then follow on consecutive cycles with the same warp.
- R5: On beat b, lane l handles thread 8*b + l. Its index appears in `lane_tid_o[5*l +: 5]`.
- R6: The enable for lane l is bit 8*b + l of the warp's mask as captured at the selection edge. Changes to `act_mask_i` or `ready_i` during the instruction have no effect on it.
- R7: The PC of the issuing warp increases by 1 at the clock edge that ends beat 3.
- R8: When no warp is eligible at a selection point, `issue_valid_o` is 0 and all lane enables are 0 on the next cycle, and the search is repeated on every cycle.
- R9: `issue_pc_o` shows the current PC of the issuing warp on all four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 24 | Per-warp ready flag; bit w belongs to warp w |
| act_mask_i | input | 768 | Per-warp active-thread masks, 32 bits per warp, warp w at bits [32w+31:32w] |
| issue_valid_o | output | 1 | An instruction beat is issuing this cycle |
| issue_warp_o | output | 5 | ID of the issuing warp |
| issue_pc_o | output | 16 | PC of the issuing warp |
| issue_beat_o | output | 2 | Beat number, 0 to 3 |
| lane_tid_o | output | 40 | Thread index per lane, 5 bits per lane, lane l at [5l+4:5l] |
| lane_en_o | output | 8 | Per-lane enable from the captured mask |

## Verification
Two things happen at the same edge at the end of an instruction: the PC of the finishing warp is incremented, and the next warp is picked. Both can target one warp. The bench provokes this by leaving a single warp eligible, so that warp is re-granted at every boundary. It then checks that the PC shown on the new beat 0 is exactly one above the PC shown on the previous beat 3. Random ready patterns and masks with some all-zero fields then make the round-robin pick collide with warps that drop out during an instruction. They also change the mask in the middle of an instruction. Each such case is judged against a cycle model kept in the bench.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  localparam int unsigned DEF_WARPS     = 24;
  localparam int unsigned DEF_WARP_SIZE = 32;
  localparam int unsigned DEF_LANES     = 8;
  localparam int unsigned DEF_PC_W      = 16;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/warp_rr_arb.sv
module warp_rr_arb #(
  parameter int unsigned N   = 24,
  parameter int unsigned IDW = 5
) (
  input  logic [N-1:0]   req_i,
  input  logic [IDW-1:0] last_i,
  output logic           any_o,
  output logic [IDW-1:0] gnt_o
);
  int unsigned idx;

  // search begins just past the last grant; the last grant itself is checked last
  always_comb begin
    any_o = 1'b0;
    gnt_o = '0;
    idx   = 0;
    for (int unsigned off = 1; off <= N; off++) begin
      idx = (int'(last_i) + off) % N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        gnt_o = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/warp_ctx_table.sv
module warp_ctx_table #(
  parameter int unsigned N    = 24,
  parameter int unsigned IDW  = 5,
  parameter int unsigned PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic [IDW-1:0]  adv_id_i,
  input  logic [IDW-1:0]  rd_id_i,
  output logic [PC_W-1:0] rd_pc_o
);
  logic [PC_W-1:0] pc_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) pc_q[i] <= '0;
    end else if (adv_i) begin
      pc_q[adv_id_i] <= pc_q[adv_id_i] + PC_W'(1);
    end
  end

  assign rd_pc_o = pc_q[rd_id_i];
endmodule

// File: rtl/lane_beat_map.sv
module lane_beat_map #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned WSIZE  = 32,
  parameter int unsigned BEAT_W = 2,
  parameter int unsigned TID_W  = 5
) (
  input  logic                   valid_i,
  input  logic [BEAT_W-1:0]      beat_i,
  input  logic [WSIZE-1:0]       mask_i,
  output logic [LANES*TID_W-1:0] tid_o,
  output logic [LANES-1:0]       en_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TID_W-1:0] tid;
    assign tid = TID_W'(int'(beat_i) * int'(LANES) + l);
    assign tid_o[l*TID_W +: TID_W] = tid;
    assign en_o[l] = valid_i & mask_i[tid];
  end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import warp_issue_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_WARPS,
  parameter int unsigned WARP_SIZE = DEF_WARP_SIZE,
  parameter int unsigned NUM_LANES = DEF_LANES,
  parameter int unsigned PC_W      = DEF_PC_W,
  localparam int unsigned BEATS    = WARP_SIZE / NUM_LANES,
  localparam int unsigned WID_W    = idx_w(NUM_WARPS),
  localparam int unsigned BEAT_W   = idx_w(BEATS),
  localparam int unsigned TID_W    = idx_w(WARP_SIZE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_WARPS-1:0]       ready_i,
  input  logic [NUM_WARPS*WARP_SIZE-1:0] act_mask_i,
  output logic                       issue_valid_o,
  output logic [WID_W-1:0]           issue_warp_o,
  output logic [PC_W-1:0]            issue_pc_o,
  output logic [BEAT_W-1:0]          issue_beat_o,
  output logic [NUM_LANES*TID_W-1:0] lane_tid_o,
  output logic [NUM_LANES-1:0]       lane_en_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [NUM_WARPS-1:0] elig;
  logic                 any;
  logic [WID_W-1:0]     gnt;
  logic [WARP_SIZE-1:0] gnt_mask;

  logic                 valid_q;
  logic [WID_W-1:0]     warp_q, last_q;
  logic [BEAT_W-1:0]    beat_q;
  logic [WARP_SIZE-1:0] mask_q;
  logic                 boundary, last_beat;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    assign elig[w] = ready_i[w] & (|act_mask_i[w*WARP_SIZE +: WARP_SIZE]);
  end

  warp_rr_arb #(.N(NUM_WARPS), .IDW(WID_W)) u_arb (
    .req_i  (elig),
    .last_i (last_q),
    .any_o  (any),
    .gnt_o  (gnt)
  );

  assign gnt_mask  = act_mask_i[int'(gnt)*WARP_SIZE +: WARP_SIZE];
  assign last_beat = valid_q && (beat_q == LAST_BEAT);
  assign boundary  = !valid_q || last_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      warp_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      last_q  <= WID_W'(NUM_WARPS - 1);
    end else if (boundary) begin
      valid_q <= any;
      if (any) begin
        warp_q <= gnt;
        beat_q <= '0;
        mask_q <= gnt_mask;
        last_q <= gnt;
      end
    end else begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  warp_ctx_table #(.N(NUM_WARPS), .IDW(WID_W), .PC_W(PC_W)) u_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (last_beat),
    .adv_id_i (warp_q),
    .rd_id_i  (warp_q),
    .rd_pc_o  (issue_pc_o)
  );

  lane_beat_map #(.LANES(NUM_LANES), .WSIZE(WARP_SIZE), .BEAT_W(BEAT_W), .TID_W(TID_W)) u_map (
    .valid_i (valid_q),
    .beat_i  (beat_q),
    .mask_i  (mask_q),
    .tid_o   (lane_tid_o),
    .en_o    (lane_en_o)
  );

  assign issue_valid_o = valid_q;
  assign issue_warp_o  = warp_q;
  assign issue_beat_o  = beat_q;

  // R2
  grant_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> elig[gnt]);

  // R4
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_beat_o != LAST_BEAT) |=>
      (issue_valid_o && issue_beat_o == $past(issue_beat_o) + BEAT_W'(1) && $stable(issue_warp_o)));

  // R6
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_beat_o != LAST_BEAT) |=> $stable(mask_q));

  // R7
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_beat && any && gnt == issue_warp_o) |=> (issue_pc_o == $past(issue_pc_o) + PC_W'(1)));

  // R8
  idle_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> (lane_en_o == '0));

  // R8
  idle_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && !any) |=> !issue_valid_o);
endmodule

// File: tb/warp_issue_seq_tb_top.sv
module warp_issue_seq_tb_top;
  localparam int NW = 24;
  localparam int WS = 32;
  localparam int NL = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NW-1:0]     ready_i = '0;
  logic [NW*WS-1:0]  act_mask_i = '0;
  logic              issue_valid_o;
  logic [4:0]        issue_warp_o;
  logic [15:0]       issue_pc_o;
  logic [1:0]        issue_beat_o;
  logic [NL*5-1:0]   lane_tid_o;
  logic [NL-1:0]     lane_en_o;

  always #5 clk_i = ~clk_i;

  warp_issue_seq dut_i (
    .clk_i, .rst_ni, .ready_i, .act_mask_i,
    .issue_valid_o, .issue_warp_o, .issue_pc_o, .issue_beat_o,
    .lane_tid_o, .lane_en_o
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit          ev = 0;
  int          ew = 0, eb = 0, elast = NW - 1;
  logic [31:0] em = '0;
  int          epc [NW];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit eligible(input int w);
    return ready_i[w] && (act_mask_i[w*WS +: WS] != '0);
  endfunction

  // model state for the next edge, from the inputs just driven
  task automatic model_step();
    if (!ev || eb == 3) begin
      if (ev) epc[ew] = epc[ew] + 1;
      ev = 0;
      for (int off = 1; off <= NW; off++) begin
        int k;
        k = (elast + off) % NW;
        if (!ev && eligible(k)) begin
          ev = 1; ew = k; eb = 0; em = act_mask_i[k*WS +: WS]; elast = k;
        end
      end
    end else begin
      eb = eb + 1;
    end
  endtask

  task automatic compare();
    chk(issue_valid_o == ev, "R4/R8 valid", int'(issue_valid_o), int'(ev));
    if (ev) begin
      chk(int'(issue_warp_o) == ew, "R2/R3 warp", int'(issue_warp_o), ew);
      chk(int'(issue_beat_o) == eb, "R4 beat", int'(issue_beat_o), eb);
      chk(int'(issue_pc_o) == epc[ew], "R7/R9 pc", int'(issue_pc_o), epc[ew]);
      for (int l = 0; l < NL; l++) begin
        chk(int'(lane_tid_o[l*5 +: 5]) == eb*8 + l, "R5 tid", int'(lane_tid_o[l*5 +: 5]), eb*8 + l);
        chk(lane_en_o[l] == em[eb*8 + l], "R6 lane_en", int'(lane_en_o[l]), int'(em[eb*8 + l]));
      end
    end else begin
      chk(lane_en_o == '0, "R8 idle lane_en", int'(lane_en_o), 0);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    for (int w = 0; w < NW; w++) epc[w] = 0;
    repeat (3) @(negedge clk_i);
    chk(issue_valid_o == 1'b0, "R1 reset valid", int'(issue_valid_o), 0);
    chk(lane_en_o == '0, "R1 reset lane_en", int'(lane_en_o), 0);
    rst_ni = 1'b1;

    // all warps ready with full masks: strict rotation from warp 0 (R1, R3)
    ready_i = '1;
    act_mask_i = '1;
    for (int c = 0; c < 110; c++) tick();

    // random readiness and masks, some all-zero, changing mid-instruction (R2, R6)
    for (int c = 0; c < 600; c++) begin
      ready_i = NW'($urandom);
      for (int w = 0; w < NW; w++)
        act_mask_i[w*WS +: WS] = ($urandom % 5 == 0) ? 32'h0 : $urandom;
      tick();
    end

    // nothing eligible: idle and re-search every cycle (R8)
    ready_i = '1;
    act_mask_i = '0;
    for (int c = 0; c < 20; c++) tick();
    ready_i = '0;
    act_mask_i = '1;
    for (int c = 0; c < 10; c++) tick();

    // single eligible warp re-granted back to back; PC step at same edge (R7, R3)
    ready_i = '0;
    ready_i[5] = 1'b1;
    act_mask_i = '1;
    act_mask_i[5*WS +: WS] = 32'hA5F0_0F3C;
    for (int c = 0; c < 40; c++) tick();

    // sparse: one lane-beat thread active in warp 23 only (R5, R6)
    ready_i = '0;
    ready_i[23] = 1'b1;
    act_mask_i = '0;
    act_mask_i[23*WS +: WS] = 32'h0001_0000;
    for (int c = 0; c < 16; c++) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule